// File: doc/BRIEF.md
# Single-Clock Diagnostic Registered Store

This block is a registered read-only word store with a built-in serial diagnostic path, running from one clock. In normal operation each rising edge loads the addressed word into an output pipeline register. In diagnostic operation the same clock drives a shadow register. That register can shift serially, load the pipeline register, or capture what is on the data pins. The two kinds of operation never happen on the same edge.

One active-low input, `dual_n`, is shared between two jobs, and a control byte picks which one. It can be an output enable, asynchronous or synchronous, or an initialize strobe that loads a stored initialize byte. While diagnostic mode is selected, the same pin instead picks between serial shifting and parallel transfer, and `sdi` gives the direction of a parallel transfer. During a parallel transfer `sdo` repeats `sdi`, so the direction reaches the next device in a chain.

A preload port fills the word array, the initialize byte and the control byte for test. The control byte takes effect at reset.

Top module: `diag_prom`

## Requirements
- R1: Preload writes go to the word array at addresses below DEPTH (DEPTH = 2^AW), to the initialize byte at address DEPTH, and to the control byte at DEPTH+1. The control byte is sampled while `rst` is high:
  - 0x01 selects synchronous enable.
  - 0x02 selects initialize.
  - Any other value selects asynchronous enable.
- R2: With `mode` low, and the pin not holding an initialize, every rising edge loads word `addr` into the pipeline register. `dout` shows it after that edge.
- R3: Asynchronous enable with `mode` low: `dout_oe` equals the inverse of `dual_n` without waiting for a clock edge.
- R4: Synchronous enable: `dout_oe` changes only at rising edges. It takes the inverse of `dual_n` as sampled at the last edge where `mode` was low.
- R5: While `mode` is high in either enable configuration, `dout_oe` is frozen. It keeps the inverse of `dual_n` sampled at the last edge with `mode` low, or 0 if there has been no such edge since reset.
- R6: In the initialize configuration `dout_oe` is always 1.
- R7: Initialize configuration with `mode` low: an edge where `dual_n` is sampled low, after being sampled high at the previous edge, loads the initialize byte into the pipeline register. Each further edge with `dual_n` low leaves `dout` unchanged.
- R8: With `mode` high and `dual_n` high, each edge shifts the shadow register left, taking `sdi` into bit 0. `dout` does not change.
- R9: With `mode` high, `dual_n` low and `sdi` low, an edge copies the shadow register into the pipeline register. The shadow register does not change.
- R10: With `mode` high, `dual_n` low and `sdi` high, an edge copies the pin value into the shadow register and leaves `dout` unchanged. The pin value is `dout` when `dout_oe` is 1 and `bus_in` otherwise.
- R11: `sdo` equals `sdi` while `mode` is high and `dual_n` is low. Otherwise `sdo` is the shadow register's most-significant bit.
- R12: Reset clears the pipeline and shadow registers, and `dout_oe` then reads 0 in synchronous enable mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for the pipeline and diagnostic paths |
| rst | input | 1 | Synchronous active-high reset; samples the control byte |
| pre_we | input | 1 | Preload write strobe |
| pre_addr | input | AW+1 | Preload address; DEPTH and DEPTH+1 reach the two special bytes |
| pre_data | input | DW | Preload write data |
| addr | input | AW | Read address for normal mode |
| mode | input | 1 | High selects diagnostic operation |
| dual_n | input | 1 | Shared enable/initialize pin; secondary select in diagnostic mode |
| sdi | input | 1 | Serial data in; transfer direction during a parallel transfer |
| bus_in | input | DW | Value an external driver puts on the data pins |
| dout | output | DW | Pipeline register contents |
| dout_oe | output | 1 | Output enable for the data pins |
| sdo | output | 1 | Serial data out, or forwarded direction |

## Verification
The bench covers the following corner cases, each paired with the failure it would expose:
- The initialize strobe is hit on its falling edge and then held low. A design that reloads on every low edge, or that keeps reading the array while the pin is low, would show the wrong word.
- The pin is toggled while in diagnostic mode under asynchronous enable. A design that fails to freeze the enable would switch its drivers while the pin acts as a secondary select.
- Captures are made both with the outputs enabled and with them disabled. A design that always captured its own register would miss the external bus value.
- `sdo` is checked during parallel transfer. A design that kept showing the shadow MSB would break a chain of devices.

// File: rtl/diag_prom_pkg.sv
package diag_prom_pkg;

  localparam int unsigned CTRL_W = 8;

  // Role of the shared pin, fixed at reset from the control byte.
  typedef enum logic [1:0] {
    PIN_EN_ASYNC = 2'd0,
    PIN_EN_SYNC  = 2'd1,
    PIN_INIT     = 2'd2
  } pin_cfg_e;

  function automatic pin_cfg_e decode_ctrl(input logic [CTRL_W-1:0] b);
    case (b)
      8'h01:   return PIN_EN_SYNC;
      8'h02:   return PIN_INIT;
      default: return PIN_EN_ASYNC;
    endcase
  endfunction

endpackage

// File: rtl/diag_prom_store.sv
module diag_prom_store
  import diag_prom_pkg::*;
#(
  parameter int unsigned AW = 11,
  parameter int unsigned DW = 8
) (
  input  logic              clk,
  input  logic              pre_we,
  input  logic [AW:0]       pre_addr,
  input  logic [DW-1:0]     pre_data,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [DW-1:0]     rd_data,
  output logic [DW-1:0]     init_byte,
  output logic [CTRL_W-1:0] ctrl_byte
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic          in_array;

  assign in_array = !pre_addr[AW];

  // Single write port plus registered read port: block RAM shape.
  always_ff @(posedge clk) begin
    if (pre_we && in_array) mem[pre_addr[AW-1:0]] <= pre_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end

  // The two bytes just above the array live in flops.
  always_ff @(posedge clk) begin
    if (pre_we && !in_array) begin
      if (pre_addr[AW-1:0] == AW'(0))      init_byte <= pre_data;
      else if (pre_addr[AW-1:0] == AW'(1)) ctrl_byte <= CTRL_W'(pre_data);
    end
  end

endmodule

// File: rtl/diag_prom_shadow.sv
module diag_prom_shadow #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          shift_en,
  input  logic          cap_en,
  input  logic          sdi,
  input  logic [DW-1:0] cap_val,
  output logic [DW-1:0] shadow,
  output logic          msb
);

  always_ff @(posedge clk) begin
    if (rst)           shadow <= '0;
    else if (shift_en) shadow <= {shadow[DW-2:0], sdi};
    else if (cap_en)   shadow <= cap_val;
  end

  assign msb = shadow[DW-1];

endmodule

// File: rtl/diag_prom_output.sv
module diag_prom_output
  import diag_prom_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  pin_cfg_e      cfg,
  input  logic          mode,
  input  logic          dual_n,
  input  logic          load_mem,
  input  logic          load_init,
  input  logic          load_shadow,
  input  logic [DW-1:0] rd_data,
  input  logic [DW-1:0] init_byte,
  input  logic [DW-1:0] shadow,
  output logic [DW-1:0] dout,
  output logic          oe
);

  logic          src_mem;  // pipeline value sits in the array's read register
  logic [DW-1:0] alt_q;    // pipeline value from initialize or shadow
  logic          held_q;   // enable sampled at last normal-mode edge

  always_ff @(posedge clk) begin
    if (rst) begin
      src_mem <= 1'b0;
      alt_q   <= '0;
    end else if (load_init) begin
      src_mem <= 1'b0;
      alt_q   <= init_byte;
    end else if (load_shadow) begin
      src_mem <= 1'b0;
      alt_q   <= shadow;
    end else if (load_mem) begin
      src_mem <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        held_q <= 1'b0;
    else if (!mode) held_q <= !dual_n;
  end

  always_comb begin
    case (cfg)
      PIN_INIT:    oe = 1'b1;
      PIN_EN_SYNC: oe = held_q;
      default:     oe = mode ? held_q : !dual_n;
    endcase
  end

  assign dout = src_mem ? rd_data : alt_q;

  a_r4_sync_enable_follows_edge: assert property (@(posedge clk) disable iff (rst)
    (cfg == PIN_EN_SYNC && !mode) |=> (oe == !$past(dual_n)));

  a_r5_enable_frozen_in_diag: assert property (@(posedge clk) disable iff (rst)
    (cfg != PIN_INIT && mode) |=> (!mode || $stable(oe)));

endmodule

// File: rtl/diag_prom.sv
module diag_prom
  import diag_prom_pkg::*;
#(
  parameter int unsigned AW = 11,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pre_we,
  input  logic [AW:0]   pre_addr,
  input  logic [DW-1:0] pre_data,
  input  logic [AW-1:0] addr,
  input  logic          mode,
  input  logic          dual_n,
  input  logic          sdi,
  input  logic [DW-1:0] bus_in,
  output logic [DW-1:0] dout,
  output logic          dout_oe,
  output logic          sdo
);

  logic [DW-1:0]     rd_data;
  logic [DW-1:0]     init_byte;
  logic [CTRL_W-1:0] ctrl_byte;
  logic [DW-1:0]     shadow;
  logic [DW-1:0]     pins;
  logic              shadow_msb;
  pin_cfg_e          cfg_q;
  logic              pin_q;
  logic              init_cfg, init_fall, init_block;
  logic              load_mem, do_shift, xfer, load_shadow, do_cap;

  // Role of the shared pin is decided only while reset is held.
  always_ff @(posedge clk) begin
    if (rst) cfg_q <= decode_ctrl(ctrl_byte);
  end

  always_ff @(posedge clk) begin
    if (rst) pin_q <= 1'b1;
    else     pin_q <= dual_n;
  end

  // Operation decode: normal and diagnostic actions are exclusive.
  assign init_cfg    = (cfg_q == PIN_INIT);
  assign init_block  = init_cfg && !mode && !dual_n;
  assign init_fall   = init_block && pin_q && !rst;
  assign load_mem    = !rst && !mode && !init_block;
  assign do_shift    = !rst && mode && dual_n;
  assign xfer        = mode && !dual_n;
  assign load_shadow = !rst && xfer && !sdi;
  assign do_cap      = !rst && xfer && sdi;
  assign pins        = dout_oe ? dout : bus_in;
  assign sdo         = xfer ? sdi : shadow_msb;

  diag_prom_store #(.AW(AW), .DW(DW)) u_store (
    .clk       (clk),
    .pre_we    (pre_we),
    .pre_addr  (pre_addr),
    .pre_data  (pre_data),
    .rd_en     (load_mem),
    .rd_addr   (addr),
    .rd_data   (rd_data),
    .init_byte (init_byte),
    .ctrl_byte (ctrl_byte)
  );

  diag_prom_shadow #(.DW(DW)) u_shadow (
    .clk      (clk),
    .rst      (rst),
    .shift_en (do_shift),
    .cap_en   (do_cap),
    .sdi      (sdi),
    .cap_val  (pins),
    .shadow   (shadow),
    .msb      (shadow_msb)
  );

  diag_prom_output #(.DW(DW)) u_output (
    .clk         (clk),
    .rst         (rst),
    .cfg         (cfg_q),
    .mode        (mode),
    .dual_n      (dual_n),
    .load_mem    (load_mem),
    .load_init   (init_fall),
    .load_shadow (load_shadow),
    .rd_data     (rd_data),
    .init_byte   (init_byte),
    .shadow      (shadow),
    .dout        (dout),
    .oe          (dout_oe)
  );

  a_r7_init_on_fall: assert property (@(posedge clk) disable iff (rst)
    (init_cfg && !mode && !dual_n && pin_q) |=> (dout == $past(init_byte)));

  a_r7_hold_while_low: assert property (@(posedge clk) disable iff (rst)
    (init_cfg && !mode && !dual_n && !pin_q) |=> $stable(dout));

  a_r8_shift_left: assert property (@(posedge clk) disable iff (rst)
    (mode && dual_n) |=>
      ((shadow == {$past(shadow[DW-2:0]), $past(sdi)}) && $stable(dout)));

  a_r9_shadow_to_pipe: assert property (@(posedge clk) disable iff (rst)
    (mode && !dual_n && !sdi) |=> ((dout == $past(shadow)) && $stable(shadow)));

  a_r10_capture_pins: assert property (@(posedge clk) disable iff (rst)
    (mode && !dual_n && sdi) |=>
      ((shadow == $past(dout_oe ? dout : bus_in)) && $stable(dout)));

endmodule

// File: tb/diag_prom_bench.sv
module diag_prom_bench;

  localparam int AW    = 11;
  localparam int DW    = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          pre_we = 1'b0;
  logic [AW:0]   pre_addr = '0;
  logic [DW-1:0] pre_data = '0;
  logic [AW-1:0] addr = '0;
  logic          mode = 1'b0;
  logic          dual_n = 1'b1;
  logic          sdi = 1'b0;
  logic [DW-1:0] bus_in = '0;
  wire  [DW-1:0] dout;
  wire           dout_oe;
  wire           sdo;

  always #2 clk = ~clk;

  diag_prom #(.AW(AW), .DW(DW)) u_diag_prom (
    .clk(clk), .rst(rst), .pre_we(pre_we), .pre_addr(pre_addr),
    .pre_data(pre_data), .addr(addr), .mode(mode), .dual_n(dual_n),
    .sdi(sdi), .bus_in(bus_in), .dout(dout), .dout_oe(dout_oe), .sdo(sdo)
  );

  int checks = 0;
  int errors = 0;

  // Reference state: 0 async enable, 1 sync enable, 2 initialize.
  int         cfg_m;
  logic [7:0] pipe_m, shadow_m;
  logic [7:0] init_m = 8'hC3;
  logic       held_m, prev_m;

  function automatic logic [7:0] word_of(int a);
    int v;
    v = (a * 29) ^ (a >> 4) ^ 32'h3C;
    return v[7:0];
  endfunction

  function automatic logic exp_oe();
    if (cfg_m == 2) return 1'b1;
    if (cfg_m == 1) return held_m;
    return mode ? held_m : !dual_n;
  endfunction

  function automatic logic exp_sdo();
    return (mode && !dual_n) ? sdi : shadow_m[7];
  endfunction

  function automatic string oe_tag();
    if (cfg_m == 2) return "R6";
    if (cfg_m == 1) return "R4";
    return mode ? "R5" : "R3";
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(bit m, bit p, bit s, int a, logic [7:0] b);
    logic [7:0] np, ns;
    logic       nh;
    string      dt;
    @(negedge clk);
    mode = m; dual_n = p; sdi = s; addr = AW'(a); bus_in = b;
    #1;
    chk(oe_tag(), dout_oe, exp_oe());
    chk("R11", sdo, exp_sdo());
    np = pipe_m; ns = shadow_m; nh = held_m;
    if (!m) begin
      nh = !p;
      if (cfg_m == 2 && !p) begin
        dt = "R7";
        if (prev_m) np = init_m;
      end else begin
        dt = "R2";
        np = word_of(a);
      end
    end else if (p) begin
      dt = "R8";
      ns = {shadow_m[6:0], s};
    end else if (!s) begin
      dt = "R9";
      np = shadow_m;
    end else begin
      dt = "R10";
      ns = exp_oe() ? pipe_m : b;
    end
    @(posedge clk);
    #1;
    pipe_m = np; shadow_m = ns; held_m = nh; prev_m = p;
    chk(dt, dout, pipe_m);
    chk(oe_tag(), dout_oe, exp_oe());
    chk("R11", sdo, exp_sdo());
  endtask

  task automatic reset_with(logic [7:0] ctrl);
    @(negedge clk);
    rst = 1'b1; mode = 1'b0; dual_n = 1'b1; sdi = 1'b0;
    pre_we = 1'b1; pre_addr = (AW+1)'(DEPTH + 1); pre_data = ctrl;
    @(negedge clk);
    pre_we = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    cfg_m = (ctrl == 8'h01) ? 1 : (ctrl == 8'h02) ? 2 : 0;
    pipe_m = 8'h00; shadow_m = 8'h00; held_m = 1'b0; prev_m = 1'b1;
    #1;
    chk("R12 pipeline cleared", dout, 8'h00);
    chk("R12 shadow msb cleared", sdo, 1'b0);
    chk("R12 enable after reset", dout_oe, exp_oe());
  endtask

  task automatic run_config(logic [7:0] ctrl);
    logic [7:0] pat;
    reset_with(ctrl);
    // R2 reads at the array boundaries, outputs disabled then enabled
    cyc(0, 1, 0, 0, 8'h00);
    cyc(0, 1, 0, DEPTH - 1, 8'h00);
    cyc(0, 0, 0, 5, 8'h00);
    cyc(0, 0, 0, 6, 8'h00);
    if (ctrl == 8'h07) begin
      chk("R1 undefined control byte gives async enable", dout_oe, 1'b1);
      chk("R1 preloaded word", dout, word_of(6));
    end
    cyc(0, 1, 0, 9, 8'h00);
    // R7 initialize strobe: fall, hold low, release
    cyc(0, 0, 0, 11, 8'h00);
    cyc(0, 0, 0, 12, 8'h00);
    cyc(0, 1, 0, 13, 8'h00);
    // R5 enable frozen while the pin selects diagnostic actions
    cyc(0, 0, 0, 14, 8'h00);
    // R8 shift a pattern in, MSB first
    pat = 8'hA5;
    for (int i = 7; i >= 0; i--) cyc(1, 1, pat[i], 0, 8'h00);
    // R9 shadow into pipeline
    cyc(1, 0, 0, 0, 8'h00);
    // R10 capture with outputs enabled, then with disabled outputs
    cyc(1, 0, 1, 0, 8'h3E);
    cyc(0, 1, 0, 20, 8'h00);
    cyc(1, 0, 1, 0, 8'h6B);
    for (int i = 0; i < 8; i++) cyc(1, 1, 1'b0, 0, 8'h00);
    // Constrained random mix
    for (int n = 0; n < 400; n++) begin
      bit m, p, s;
      m = ($urandom % 3) == 0;
      p = ($urandom % 4) != 0;
      s = $urandom % 2;
      cyc(m, p, s, int'($urandom % DEPTH), 8'($urandom));
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1;
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk);
      pre_we = 1'b1; pre_addr = (AW+1)'(a); pre_data = word_of(a);
    end
    @(negedge clk);
    pre_addr = (AW+1)'(DEPTH); pre_data = init_m;
    @(negedge clk);
    pre_we = 1'b0;
    run_config(8'h00);
    run_config(8'h01);
    run_config(8'h02);
    run_config(8'h07);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #600000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule